// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that copies 32-bit words from one memory address range to another through a simple request/acknowledge memory master port. Software programs it through seven word-indexed registers on a register write port with a combinational read-back. In direct mode software loads the source, destination and byte count and starts one transfer. In linked mode the channel reads four-word descriptors from memory, moves one segment per descriptor, and follows the next-descriptor pointer until a descriptor carries the last-in-chain flag.

Start and stop are set by a run bit that only software writes. A separate resume bit re-launches an idle linked channel after software has edited descriptors. The channel clears the resume bit as it starts. Completion, segment and bus-error events are sticky in a status register and are combined into one interrupt line.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `mem_req` is 0.
- R2: Register word indexes are: 0 control, 1 status, 2 current descriptor pointer, 3 source, 4 destination, 5 byte count, 6 next descriptor pointer. Control keeps only bit 0 RUN, bit 1 RESUME, bit 2 DIRECT, bit 6 done-interrupt enable and bit 7 error-interrupt enable, and all other bits read 0. Byte count stores its low 26 bits, and bits 31:26 read 0.
- R3: An idle channel starts when RUN is 1 and either RUN was just written from 0 to 1 or RESUME is 1. Starting clears RESUME. Hardware never changes RUN.
- R4: Writing RUN to 0 while busy stops the channel: the busy flag (status bit 2) reads 0 two clock edges after the write, memory requests stop, and no event bit is set.
- R5: With DIRECT=1 the channel copies byte-count/4 words, each as a read from the source then a write to the destination. Source and destination step by 4 and the byte count drops by 4 per word. At the end status bit 0 (done) is set.
- R6: With DIRECT=0 the channel reads the four words at (pointer & ~31) + 0, 4, 8, 12 into source, destination, next pointer and byte count, then runs the segment. If next-pointer bit 0 is 1 the chain ends with done set. Otherwise the current pointer takes the next-pointer value and the channel fetches again.
- R7: At the end of a linked segment whose next-pointer bit 1 is 1, status bit 1 (segment event) is set. Direct mode never sets it.
- R8: A byte count of zero completes the segment with no data memory access.
- R9: While busy, writes to the source, destination, byte count and current pointer registers are ignored. The next pointer is never writable by software.
- R10: Status bits 0, 1, 4 and 7 are cleared by writing 1 to them. Writing 0 leaves them unchanged. If hardware sets a bit in the same cycle as the clear, the set wins.
- R11: `mem_err` with `mem_ack` on a read sets status bit 7 (read fault). On a write it sets status bit 4 (write fault). Either way the faulting access has no effect and the channel stops with busy 0.
- R12: `irq` = (done AND done-enable) OR ((read fault OR write fault) AND error-enable) OR segment event.
- R13: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the cycle `mem_req` rises until `mem_ack`. `mem_we` is never 1 without `mem_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (one-cycle pulse) |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Bus error, valid with `mem_ack` |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle. The memory request holds steady until it is acknowledged. RUN changes only on a control write. RESUME is clear after a start. A halt or a bus fault leaves the channel idle on the next cycle. Busy writes do not reach the source register. `irq` is never raised without a pending event. Other behaviour is shown only by the bench scenarios: the data a transfer leaves in memory, the descriptor walk and its end, the access counts for zero-length segments, the restart through RESUME, and the priority between clearing and setting status bits.

// File: rtl/dmac_pkg.sv
// Shared definitions for the linked-descriptor DMA channel.
// Assumes a 3-bit register word index on the register port.
package dmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_SEGEND
    } seq_state_t;

    localparam logic [2:0] RI_CTRL = 3'd0;
    localparam logic [2:0] RI_STAT = 3'd1;
    localparam logic [2:0] RI_CUR  = 3'd2;
    localparam logic [2:0] RI_SRC  = 3'd3;
    localparam logic [2:0] RI_DST  = 3'd4;
    localparam logic [2:0] RI_CNT  = 3'd5;
    localparam logic [2:0] RI_NXT  = 3'd6;
endpackage

// File: rtl/dmac_seq.sv
// Transfer sequencer: walks descriptor fetches and word copies, issues the
// memory request and reports events as one-cycle strobes to the register file.
// Assumes mem_ack/mem_err are one-cycle responses to a held request.
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int unsigned DESC_WORDS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       halt,
    input  logic       chain,
    input  logic       cnt_zero,
    input  logic       last_seg,
    input  logic       mem_ack,
    input  logic       mem_err,
    output seq_state_t st,
    output logic [$clog2(DESC_WORDS)-1:0] widx,
    output logic       busy,
    output logic       mem_req,
    output logic       mem_we,
    output logic       ev_fetch,
    output logic       ev_rd,
    output logic       ev_step,
    output logic       ev_segend,
    output logic       ev_advance,
    output logic       ev_finish,
    output logic       ev_err_rd,
    output logic       ev_err_wr
);
    localparam int unsigned IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic acc;

    // Request and strobe decode from the current state
    always_comb begin
        busy       = (st != ST_IDLE);
        mem_req    = (st == ST_FETCH) || (st == ST_READ) || (st == ST_WRITE);
        mem_we     = (st == ST_WRITE);
        acc        = mem_req && mem_ack && !halt;
        ev_fetch   = (st == ST_FETCH) && acc && !mem_err;
        ev_rd      = (st == ST_READ)  && acc && !mem_err;
        ev_step    = (st == ST_WRITE) && acc && !mem_err;
        ev_err_rd  = acc && mem_err && !mem_we;
        ev_err_wr  = acc && mem_err && mem_we;
        ev_segend  = (st == ST_SEGEND) && !halt;
        ev_advance = ev_segend && chain && !last_seg;
        ev_finish  = ev_segend && !(chain && !last_seg);
    end

    // State register and descriptor word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            widx <= '0;
        end else if (halt) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st   <= chain ? ST_FETCH : ST_CHECK;
                    widx <= '0;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err)               st <= ST_IDLE;
                    else if (widx == LAST_IDX) st <= ST_CHECK;
                    else                       widx <= widx + 1'b1;
                end
                ST_CHECK: st <= cnt_zero ? ST_SEGEND : ST_READ;
                ST_READ:  if (mem_ack) st <= mem_err ? ST_IDLE : ST_WRITE;
                ST_WRITE: if (mem_ack) st <= mem_err ? ST_IDLE : ST_CHECK;
                ST_SEGEND: begin
                    st   <= (chain && !last_seg) ? ST_FETCH : ST_IDLE;
                    widx <= '0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_err_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err_rd || ev_err_wr) |=> !busy);
    p_we_needs_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
    p_halt_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !busy);
endmodule

// File: rtl/dmac_status.sv
// Status register: sticky event bits with write-one-to-clear, busy flag
// read-back and interrupt combine. Assumes the set strobes are single cycle.
module dmac_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        w1c,
    input  logic [31:0] wdata,
    input  logic        set_done,
    input  logic        set_seg,
    input  logic        set_wfault,
    input  logic        set_rfault,
    input  logic        done_ie,
    input  logic        err_ie,
    output logic [31:0] status,
    output logic        irq
);
    logic done_f, seg_f, wfault_f, rfault_f;

    // Sticky event bits; a hardware set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f   <= 1'b0;
            seg_f    <= 1'b0;
            wfault_f <= 1'b0;
            rfault_f <= 1'b0;
        end else begin
            done_f   <= set_done   | (done_f   & ~(w1c & wdata[0]));
            seg_f    <= set_seg    | (seg_f    & ~(w1c & wdata[1]));
            wfault_f <= set_wfault | (wfault_f & ~(w1c & wdata[4]));
            rfault_f <= set_rfault | (rfault_f & ~(w1c & wdata[7]));
        end
    end

    // Read-back word and interrupt combine
    always_comb begin
        status = {24'd0, rfault_f, 2'b00, wfault_f, 1'b0, busy, seg_f, done_f};
        irq    = (done_f & done_ie) | ((wfault_f | rfault_f) & err_ie) | seg_f;
    end

    p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_f | seg_f | wfault_f | rfault_f));
    p_w1c_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && wdata[0] && !set_done) |=> !done_f);
endmodule

// File: rtl/dma_chain_ctrl.sv
// Single DMA channel with direct and linked-descriptor modes. Holds the
// control and address registers, multiplexes the memory address and the
// register read-back, and instantiates the sequencer and status logic.
// Assumes 32-bit words, byte counts in multiples of 4 and 32-byte aligned
// descriptors of four words (source, destination, next pointer, count).
module dma_chain_ctrl #(
    parameter int unsigned CNT_W = 26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        irq
);
    import dmac_pkg::*;

    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned ALIGN_LSB  = 5;
    localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
    localparam logic [CNT_W-1:0] BEAT  = CNT_W'(4);

    logic run, resume, direct, done_ie, err_ie, armed;
    logic [31:0] cur_ptr, nxt_ptr, src, dst, dbuf, status;
    logic [CNT_W-1:0] cnt;
    logic wr_ctrl, wr_stat, wr_cur, wr_src, wr_dst, wr_cnt;
    logic busy, halt, start;
    seq_state_t st;
    logic [IDX_W-1:0] widx;
    logic ev_fetch, ev_rd, ev_step, ev_segend, ev_advance, ev_finish, ev_err_rd, ev_err_wr;

    // Register write decode and channel control terms
    always_comb begin
        wr_ctrl = reg_we && (reg_addr == RI_CTRL);
        wr_stat = reg_we && (reg_addr == RI_STAT);
        wr_cur  = reg_we && (reg_addr == RI_CUR) && !busy;
        wr_src  = reg_we && (reg_addr == RI_SRC) && !busy;
        wr_dst  = reg_we && (reg_addr == RI_DST) && !busy;
        wr_cnt  = reg_we && (reg_addr == RI_CNT) && !busy;
        halt    = busy && !run;
        start   = !busy && run && (armed || resume);
    end

    // Control register; RESUME and the start arm are consumed by a start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {run, resume, direct, done_ie, err_ie, armed} <= '0;
        end else if (wr_ctrl) begin
            run     <= reg_wdata[0];
            resume  <= reg_wdata[1];
            direct  <= reg_wdata[2];
            done_ie <= reg_wdata[6];
            err_ie  <= reg_wdata[7];
            armed   <= reg_wdata[0] & ~run;
        end else if (start) begin
            resume <= 1'b0;
            armed  <= 1'b0;
        end
    end

    // Source, destination and count: descriptor load, per-word step, software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
        end else if (ev_fetch) begin
            if (widx == IDX_W'(0)) src <= mem_rdata;
            if (widx == IDX_W'(1)) dst <= mem_rdata;
            if (widx == IDX_W'(3)) cnt <= mem_rdata[CNT_W-1:0];
        end else if (ev_step) begin
            src <= src + 32'd4;
            dst <= dst + 32'd4;
            cnt <= cnt - BEAT;
        end else begin
            if (wr_src) src <= reg_wdata;
            if (wr_dst) dst <= reg_wdata;
            if (wr_cnt) cnt <= reg_wdata[CNT_W-1:0];
        end
    end

    // Descriptor pointers: next from the fetch, current on advance or software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            nxt_ptr <= '0;
        end else begin
            if (ev_fetch && widx == IDX_W'(2)) nxt_ptr <= mem_rdata;
            if (ev_advance)  cur_ptr <= nxt_ptr;
            else if (wr_cur) cur_ptr <= reg_wdata;
        end
    end

    // Data word held between the read and the write of one copy
    always_ff @(posedge clk) begin
        if (!rst_n)     dbuf <= '0;
        else if (ev_rd) dbuf <= mem_rdata;
    end

    // Memory address selection by sequencer phase
    always_comb begin
        mem_wdata = dbuf;
        unique case (st)
            ST_FETCH: mem_addr = {cur_ptr[31:ALIGN_LSB], {(ALIGN_LSB-IDX_W-2){1'b0}}, widx, 2'b00};
            ST_READ:  mem_addr = src;
            ST_WRITE: mem_addr = dst;
            default:  mem_addr = '0;
        endcase
    end

    // Register read-back
    always_comb begin
        unique case (reg_addr)
            RI_CTRL: reg_rdata = {24'd0, err_ie, done_ie, 3'b000, direct, resume, run};
            RI_STAT: reg_rdata = status;
            RI_CUR:  reg_rdata = cur_ptr;
            RI_SRC:  reg_rdata = src;
            RI_DST:  reg_rdata = dst;
            RI_CNT:  reg_rdata = {{(32-CNT_W){1'b0}}, cnt};
            RI_NXT:  reg_rdata = nxt_ptr;
            default: reg_rdata = '0;
        endcase
    end

    dmac_seq #(.DESC_WORDS(DESC_WORDS)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .chain(!direct),
        .cnt_zero(cnt == '0), .last_seg(nxt_ptr[0]), .mem_ack(mem_ack), .mem_err(mem_err),
        .st(st), .widx(widx), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .ev_fetch(ev_fetch), .ev_rd(ev_rd), .ev_step(ev_step), .ev_segend(ev_segend),
        .ev_advance(ev_advance), .ev_finish(ev_finish), .ev_err_rd(ev_err_rd), .ev_err_wr(ev_err_wr)
    );

    dmac_status status_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .w1c(wr_stat), .wdata(reg_wdata),
        .set_done(ev_finish), .set_seg(ev_segend && !direct && nxt_ptr[1]),
        .set_wfault(ev_err_wr), .set_rfault(ev_err_rd),
        .done_ie(done_ie), .err_ie(err_ie), .status(status), .irq(irq)
    );

    p_run_sw_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(run));
    p_resume_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wr_ctrl) |=> !resume);
    p_busy_src_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == RI_SRC && !ev_step && !ev_fetch) |=> $stable(src));
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !halt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/dma_chain_ctrl_tb_top.sv
`timescale 1ns/100ps
module dma_chain_ctrl_tb_top;
    localparam int LAT = 1;
    // Vector fields: [0] src, [1] dst, [2] byte count, [3] done-interrupt enable
    localparam logic [31:0] VEC [4][4] = '{
        '{32'h040, 32'h300, 32'd16, 32'd1},
        '{32'h080, 32'h340, 32'd4,  32'd0},
        '{32'h0C0, 32'h380, 32'd0,  32'd1},
        '{32'h044, 32'h3C0, 32'd32, 32'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic mem_ack = 1'b0;
    logic mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [256];
    logic pl_we = 1'b0;
    logic [7:0] pl_idx = '0;
    logic [31:0] pl_data = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int lat_cnt = 0;
    int acc_cnt = 0;
    int hold_bad = 0;
    int n_chk = 0;
    int n_bad = 0;
    logic p_req = 1'b0, p_ack = 1'b0;
    logic [31:0] p_addr = '0;

    always #2 clk = ~clk;

    dma_chain_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
    );

    // Memory model: acknowledges after LAT wait cycles, faults on err_addr
    always @(posedge clk) begin
        if (pl_we) mem[pl_idx] <= pl_data;
        if (mem_req && !mem_ack) begin
            if (lat_cnt == LAT) begin
                mem_ack   <= 1'b1;
                lat_cnt   <= 0;
                mem_err   <= (mem_addr == err_addr);
                acc_cnt   <= acc_cnt + 1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we && mem_addr != err_addr) mem[mem_addr[9:2]] <= mem_wdata;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            lat_cnt <= 0;
        end
    end

    // Request-hold monitor (R13)
    always @(negedge clk) begin
        if (p_req && !p_ack && mem_req && mem_addr != p_addr) hold_bad++;
        p_req  <= mem_req;
        p_ack  <= mem_ack;
        p_addr <= mem_addr;
    end

    function automatic logic [31:0] fill(int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic preload(int i, logic [31:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_idx = 8'(i); pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        @(negedge clk);
        for (int k = 0; k < 3000; k++) begin
            rd(3'd1, s);
            if (!s[2]) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 256; i++) preload(i, fill(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1", "register after reset", v, 32'd0);
        end
        chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
        chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

        // Table-driven direct transfers (R5, R7, R8, R12, R3)
        for (int n = 0; n < 4; n++) begin
            wr(3'd0, 32'h0);
            wr(3'd3, VEC[n][0]);
            wr(3'd4, VEC[n][1]);
            wr(3'd5, VEC[n][2]);
            wr(3'd1, 32'h93);
            base = acc_cnt;
            wr(3'd0, (VEC[n][3] << 6) | 32'h5);
            wait_idle();
            for (int k = 0; k < int'(VEC[n][2]) / 4; k++)
                chk("R5", "copied word", mem[(VEC[n][1] >> 2) + k], fill(int'(VEC[n][0] >> 2) + k));
            rd(3'd3, v); chk("R5", "source end", v, VEC[n][0] + VEC[n][2]);
            rd(3'd4, v); chk("R5", "destination end", v, VEC[n][1] + VEC[n][2]);
            rd(3'd5, v); chk("R5", "count end", v, 32'd0);
            rd(3'd1, v); chk("R7", "status done only", v, 32'h1);
            chk("R12", "irq follows done enable", {31'd0, irq}, VEC[n][3]);
            rd(3'd0, v); chk("R3", "RUN kept", v, (VEC[n][3] << 6) | 32'h5);
            chk("R8", "access count", 32'(acc_cnt - base), VEC[n][2] / 2);
        end

        // R2: control and count field masks
        wr(3'd0, 32'hFFFF_FFFE);
        rd(3'd0, v); chk("R2", "control mask", v, 32'hC6);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R2", "count upper bits", v, 32'h03FF_FFFF);
        wr(3'd6, 32'h1234_5678);
        rd(3'd6, v); chk("R9", "next pointer read-only", v, 32'd0);

        // R6, R7: two-descriptor chain
        preload(64, 32'h000); preload(65, 32'h200); preload(66, 32'h122); preload(67, 32'd8);
        preload(72, 32'h010); preload(73, 32'h280); preload(74, 32'h001); preload(75, 32'd4);
        wr(3'd2, 32'h100);
        wr(3'd1, 32'h93);
        base = acc_cnt;
        wr(3'd0, 32'h41);
        wait_idle();
        chk("R6", "seg0 word0", mem[128], fill(0));
        chk("R6", "seg0 word1", mem[129], fill(1));
        chk("R6", "seg1 word0", mem[160], fill(4));
        rd(3'd2, v); chk("R6", "current pointer", v, 32'h122);
        rd(3'd6, v); chk("R6", "next pointer", v, 32'h001);
        rd(3'd1, v); chk("R7", "status done+segment", v, 32'h3);
        chk("R12", "irq chain", {31'd0, irq}, 32'd1);
        chk("R6", "chain accesses", 32'(acc_cnt - base), 32'd14);

        // R3: RESUME restarts an idle linked channel and is cleared
        wr(3'd1, 32'h93);
        base = acc_cnt;
        wr(3'd0, 32'h43);
        wait_idle();
        rd(3'd0, v); chk("R3", "RESUME cleared", v, 32'h41);
        rd(3'd1, v); chk("R3", "resume done", v, 32'h1);
        chk("R3", "resume accesses", 32'(acc_cnt - base), 32'd6);

        // R9: writes while busy are ignored
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h140); wr(3'd4, 32'h240); wr(3'd5, 32'd64);
        wr(3'd0, 32'h5);
        repeat (6) @(negedge clk);
        wr(3'd3, 32'h3F0); wr(3'd4, 32'h3F0); wr(3'd2, 32'h3E0); wr(3'd5, 32'd4);
        wait_idle();
        rd(3'd3, v); chk("R9", "source kept", v, 32'h180);
        rd(3'd4, v); chk("R9", "destination kept", v, 32'h280);
        rd(3'd5, v); chk("R9", "count kept", v, 32'd0);
        rd(3'd2, v); chk("R9", "pointer kept", v, 32'h122);
        for (int k = 0; k < 16; k++) chk("R9", "busy copy word", mem[144 + k], fill(80 + k));

        // R4: halt
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h93);
        wr(3'd3, 32'h180); wr(3'd4, 32'h2C0); wr(3'd5, 32'd64);
        wr(3'd0, 32'h5);
        repeat (8) @(negedge clk);
        rd(3'd1, v); chk("R4", "busy before halt", v, 32'h4);
        wr(3'd0, 32'h4);
        rd(3'd1, v); chk("R4", "status after halt", v, 32'h0);
        base = acc_cnt;
        repeat (6) @(negedge clk);
        chk("R4", "no access after halt", 32'(acc_cnt - base), 32'd0);
        rd(3'd5, v); chk("R4", "partial count", {31'd0, (v != 0 && v < 64)}, 32'd1);

        // R11, R12, R10: write fault, then read fault
        wr(3'd0, 32'h0);
        err_addr = 32'h304;
        wr(3'd3, 32'h040); wr(3'd4, 32'h300); wr(3'd5, 32'd16);
        wr(3'd0, 32'h85);
        wait_idle();
        rd(3'd1, v); chk("R11", "write fault status", v, 32'h10);
        rd(3'd5, v); chk("R11", "count at fault", v, 32'd12);
        chk("R12", "irq on fault", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R10", "write zero no effect", v, 32'h10);
        wr(3'd1, 32'h10);
        rd(3'd1, v); chk("R10", "write one clears", v, 32'h0);
        chk("R12", "irq cleared", {31'd0, irq}, 32'd0);

        wr(3'd0, 32'h0);
        err_addr = 32'h048;
        wr(3'd3, 32'h040); wr(3'd4, 32'h300); wr(3'd5, 32'd16);
        wr(3'd0, 32'h5);
        wait_idle();
        rd(3'd1, v); chk("R11", "read fault status", v, 32'h80);
        rd(3'd5, v); chk("R11", "count at read fault", v, 32'd8);
        chk("R12", "irq masked", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'h85);
        rd(3'd1, v); chk("R3", "no restart without edge", v, 32'h80);
        chk("R12", "irq unmasked", {31'd0, irq}, 32'd1);
        wr(3'd1, 32'h80);
        rd(3'd1, v); chk("R10", "read fault cleared", v, 32'h0);
        err_addr = 32'hFFFF_FFFF;

        chk("R13", "request hold violations", 32'(hold_bad), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule